// File: doc/BRIEF.md
# I2C Master STOP Sequencer

This block produces the STOP condition on an I2C bus on behalf of a master, and watches the bus for another master while it does so. It never drives a line high. Each line has an enable that either pulls the line low or lets it float, and each line is read back through its own two-flop synchronizer. A one-cycle request starts the sequence. The master's other logic is expected to be holding SCL low when the request arrives.

The sequence has four phases. First SDA is pulled low, and SCL is held low alongside it. Once SDA reads back low, SCL is let go. The phase timer only starts after SCL actually reads high, which lets a slave stretch the clock. When that high phase expires, SDA is released. After its own phase, and after the synchronizer has had time to settle, SDA is sampled.

The sequence ends in one of two ways:
- SDA reads high: the completion flag is set.
- SDA still reads low, or SCL drops while SDA is still held low: the collision flag is set, both lines are let go at once and the block goes idle.

Both flags are sticky. A one-cycle clear input resets them.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset both line enables are inactive (lines released), `busy` is 0 and both flags are 0.
- R2: An accepted request pulls both SCL and SDA low in the next cycle. SCL is released only once SDA has read back low, exactly max(reload,2)+1 clock edges after the edge that accepted the request. SDA stays driven low at that point.
- R3: The high-phase timer starts only once the synchronized SCL reads high. With no stretching, SDA is released reload+4 edges after SCL is released. Every cycle a slave holds SCL low after its release adds one edge.
- R4: A reload value of 0 still gives a one-cycle phase, so SDA is released 4 edges after SCL.
- R5: When SDA reads high at the end of its phase, the completion flag rises, with no collision flag. This happens max(reload,2)+1 edges after SDA is released, and `busy` falls on the same edge.
- R6: If SDA still reads low at the end of its phase, the collision flag rises instead, on that same edge. Both line enables are deactivated and `busy` is 0.
- R7: If the synchronized SCL reads low after it has been seen high, and before SDA is released, a collision is flagged. This happens three edges after the line is pulled low. Both lines are released at once and the block goes idle.
- R8: `busy` stays 1 from the accepted request until the sequence ends, then returns to 0. A request while `busy` is 1 is ignored and changes no timing. While idle, neither line is driven.
- R9: Both flags stay set until a one-cycle `flag_clr` clears them together. A flag set on the same edge as a clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle request to generate a STOP |
| flag_clr | input | 1 | One-cycle clear of both sticky flags |
| reload | input | 7 | Phase timer reload value; each phase lasts reload+1 cycles |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | STOP sequence in progress (self-clearing request bit) |
| done_flag | output | 1 | Sticky: STOP completed normally |
| coll_flag | output | 1 | Sticky: bus collision during STOP |

## Verification
The bench counts edges between the line transitions, with reload values of 0, 1 and above 2. A design that starts its timer on SCL release rather than on SCL read high shows up in two ways: it ignores a stretched clock, and it gives a short high phase. A design that samples SDA before the synchronizer settles flags a false collision when the reload is small. The bench makes each collision case happen at a known edge. A design that missed either case, or kept driving a line after the collision, is caught by the flags and enables it reports. The bench also sends a request in the middle of a sequence and asserts a clear on the very edge a flag is set. This catches a design that restarts on the second request, or one that lets the clear win.

// File: rtl/i2cstop_pkg.sv
package i2cstop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SDA_LOW  = 3'd1,
        ST_SCL_WAIT = 3'd2,
        ST_SCL_HIGH = 3'd3,
        ST_SDA_REL  = 3'd4
    } stop_state_e;

endpackage

// File: rtl/i2cstop_sync.sv
module i2cstop_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= chain_d;
        end

        assign dout[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2cstop_timer.sv
module i2cstop_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)            cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/i2cstop_flags.sv
module i2cstop_flags #(
    parameter int NFLAGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set,
    input  logic              clr,
    output logic [NFLAGS-1:0] flags
);

    logic [NFLAGS-1:0] flag_d, flag_q;

    for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
        always_comb begin
            if (set[f])   flag_d[f] = 1'b1;
            else if (clr) flag_d[f] = 1'b0;
            else          flag_d[f] = flag_q[f];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;

endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
    import i2cstop_pkg::*;
#(
    parameter int RELOAD_W    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                flag_clr,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                scl_drive_low,
    output logic                sda_drive_low,
    output logic                busy,
    output logic                done_flag,
    output logic                coll_flag
);

    localparam int SETTLE_W = $clog2(SYNC_STAGES + 1);
    localparam logic [SETTLE_W-1:0] SETTLE_MAX = SETTLE_W'(SYNC_STAGES);
    localparam int FLAG_DONE = 0;
    localparam int FLAG_COLL = 1;

    typedef struct packed {
        stop_state_e         state;
        logic [SETTLE_W-1:0] settle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       scl_s, sda_s;
    logic [1:0] line_s;
    logic       tmr_load, tmr_zero;
    logic [1:0] flag_set, flag_vec;

    i2cstop_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cstop_timer #(.CNT_W(RELOAD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(reload),
        .zero    (tmr_zero)
    );

    i2cstop_flags #(.NFLAGS(2)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set),
        .clr  (flag_clr),
        .flags(flag_vec)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        flag_set = '0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (stop_req) begin
                    ctl_d.state = ST_SDA_LOW;
                    tmr_load    = 1'b1;
                end
            end
            ST_SDA_LOW: begin
                if (tmr_zero && !sda_s) ctl_d.state = ST_SCL_WAIT;
            end
            ST_SCL_WAIT: begin
                if (scl_s) begin
                    ctl_d.state = ST_SCL_HIGH;
                    tmr_load    = 1'b1;
                end
            end
            ST_SCL_HIGH: begin
                if (!scl_s) begin
                    flag_set[FLAG_COLL] = 1'b1;
                    ctl_d.state         = ST_IDLE;
                end else if (tmr_zero) begin
                    ctl_d.state  = ST_SDA_REL;
                    ctl_d.settle = '0;
                    tmr_load     = 1'b1;
                end
            end
            ST_SDA_REL: begin
                if (ctl_q.settle != SETTLE_MAX) begin
                    ctl_d.settle = ctl_q.settle + SETTLE_W'(1);
                end else if (tmr_zero) begin
                    if (sda_s) flag_set[FLAG_DONE] = 1'b1;
                    else       flag_set[FLAG_COLL] = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.settle <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scl_drive_low = (ctl_q.state == ST_SDA_LOW);
    assign sda_drive_low = (ctl_q.state == ST_SDA_LOW)  ||
                           (ctl_q.state == ST_SCL_WAIT) ||
                           (ctl_q.state == ST_SCL_HIGH);
    assign busy          = (ctl_q.state != ST_IDLE);
    assign done_flag     = flag_vec[FLAG_DONE];
    assign coll_flag     = flag_vec[FLAG_COLL];

endmodule

// File: rtl/i2c_stop_gen_chk.sv
module i2c_stop_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic flag_clr,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic busy,
    input logic done_flag,
    input logic coll_flag
);

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low)); // R8

    AST_REQ_PULLS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sda_drive_low && scl_drive_low)); // R2

    AST_SCL_FREE_SDA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> sda_drive_low); // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(done_flag) && $rose(coll_flag))); // R5

    AST_DONE_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !busy); // R5

    AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> (!busy && !scl_drive_low && !sda_drive_low)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag); // R9

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_flag && !flag_clr) |=> coll_flag); // R9

endmodule

bind i2c_stop_gen i2c_stop_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_clr     (flag_clr),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .busy         (busy),
    .done_flag    (done_flag),
    .coll_flag    (coll_flag)
);

// File: tb/i2c_stop_gen_bench.sv
module i2c_stop_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       flag_clr = 1'b0;
    logic [6:0] reload = 7'd0;
    logic       scl_hold = 1'b0;
    logic       sda_hold = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_drive_low, sda_drive_low, busy, done_flag, coll_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign scl_in = !(scl_drive_low || scl_hold);
    assign sda_in = !(sda_drive_low || sda_hold);

    i2c_stop_gen u_i2c_stop_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req     (stop_req),
        .flag_clr     (flag_clr),
        .reload       (reload),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low),
        .busy         (busy),
        .done_flag    (done_flag),
        .coll_flag    (coll_flag)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int max2(input int v);
        return (v > 2) ? v : 2;
    endfunction

    task automatic pulse_clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic start_and_reach_scl_release(input int rl, input string req);
        int n;
        reload = 7'(rl);
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        check_eq("R2", "busy after request", int'(busy), 1);
        check_eq("R2", "SDA and SCL pulled", int'(sda_drive_low && scl_drive_low), 1);
        n = 0;
        while (scl_drive_low && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check_eq(req, "edges to SCL release", n, max2(rl) + 1);
        check_eq("R2", "SDA held at SCL release", int'(sda_drive_low), 1);
    endtask

    task automatic t_reset();
        check_eq("R1", "SCL enable", int'(scl_drive_low), 0);
        check_eq("R1", "SDA enable", int'(sda_drive_low), 0);
        check_eq("R1", "busy", int'(busy), 0);
        check_eq("R1", "flags", int'({done_flag, coll_flag}), 0);
    endtask

    task automatic t_normal(input int rl, input int stretch, input bit extra_req, input string tag);
        int n;
        pulse_clr();
        start_and_reach_scl_release(rl, "R2");
        if (stretch > 0) scl_hold = 1'b1;
        n = 0;
        while (sda_drive_low && n < 1000) begin
            @(negedge clk);
            n++;
            if (n == stretch) scl_hold = 1'b0;
            stop_req = (extra_req && n == 2);
        end
        stop_req = 1'b0;
        check_eq(tag, "edges SCL release to SDA release", n, rl + 4 + stretch);
        n = 0;
        while (!done_flag && !coll_flag && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check_eq("R5", "edges SDA release to done", n, max2(rl) + 1);
        check_eq("R5", "done set, coll clear", int'({done_flag, coll_flag}), 2);
        check_eq("R8", "busy cleared at end", int'(busy), 0);
        repeat (4) @(negedge clk);
        check_eq("R8", "idle stays idle, lines released",
                 int'({busy, scl_drive_low, sda_drive_low}), 0);
    endtask

    task automatic t_coll_sda(input int rl);
        int n;
        pulse_clr();
        start_and_reach_scl_release(rl, "R2");
        n = 0;
        while (sda_drive_low && n < 1000) begin
            @(negedge clk);
            n++;
        end
        sda_hold = 1'b1;
        n = 0;
        while (!done_flag && !coll_flag && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check_eq("R6", "edges SDA release to collision", n, max2(rl) + 1);
        check_eq("R6", "coll set, done clear", int'({done_flag, coll_flag}), 1);
        check_eq("R6", "lines released, idle", int'({busy, scl_drive_low, sda_drive_low}), 0);
        sda_hold = 1'b0;
    endtask

    task automatic t_coll_scl();
        int n;
        logic sda_before;
        sda_before = 1'b0;
        pulse_clr();
        start_and_reach_scl_release(20, "R2");
        n = 0;
        while (!coll_flag && !done_flag && n < 100) begin
            @(negedge clk);
            n++;
            if (n == 5) scl_hold = 1'b1;
            if (n == 7) sda_before = sda_drive_low;
        end
        check_eq("R7", "edges to SCL collision", n, 8);
        check_eq("R7", "SDA still held before collision", int'(sda_before), 1);
        check_eq("R7", "coll set, done clear", int'({done_flag, coll_flag}), 1);
        check_eq("R7", "lines released, idle", int'({busy, scl_drive_low, sda_drive_low}), 0);
        scl_hold = 1'b0;
    endtask

    task automatic t_clear();
        repeat (5) @(negedge clk);
        check_eq("R9", "coll sticky without clear", int'(coll_flag), 1);
        pulse_clr();
        check_eq("R9", "flags cleared", int'({done_flag, coll_flag}), 0);
    endtask

    task automatic t_clr_race(input int rl);
        int n;
        pulse_clr();
        start_and_reach_scl_release(rl, "R2");
        n = 0;
        while (sda_drive_low && n < 1000) begin
            @(negedge clk);
            n++;
        end
        n = 0;
        while (n < max2(rl)) begin
            @(negedge clk);
            n++;
        end
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check_eq("R9", "set wins over clear", int'(done_flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal(5, 0, 1'b0, "R3");
        t_normal(0, 0, 1'b0, "R4");
        t_normal(1, 0, 1'b0, "R4");
        t_normal(3, 6, 1'b0, "R3");
        t_normal(4, 0, 1'b1, "R8");
        t_coll_sda(6);
        t_coll_sda(0);
        t_coll_scl();
        t_clear();
        t_clr_race(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule